// File: doc/BRIEF.md
# Processor Status Register with Write Arbitration

This block holds an 8-bit processor status word: the three arithmetic flags (carry, digit carry, zero), two read-only reset-cause bits (time-out and power-down) and three data-memory bank select bits. Any instruction may name the register as its destination. The block decides, bit by bit, whether the explicit write or the ALU result lands in each flag.

A flag that the same instruction also updates through the ALU takes the ALU value, and the written value is dropped. A flag that the instruction does not touch takes the written value. The reset-cause bits change only through dedicated event strobes and never through a write. The bank select bits are driven out continuously, so that data-memory addresses can be formed from them.

Top module: `status_reg_arb`

## Requirements
- R1: While rst_n is low, and after it is released with no other activity, status reads 0x18: TO (bit 4) and PD (bit 3) are 1, all other bits are 0, and bank_rp and bank_irp are 0.
- R2: With wr_en high and alu_upd low, bits 7:5 and 2:0 of status take wr_data on the next clock edge.
- R3: With alu_upd high, each flag whose alu_mask bit is set takes the matching alu_flags bit on the next edge, even when wr_en is also high. Mask and flag bits map as bit0 = carry (status bit 0), bit1 = digit carry (status bit 1) and bit2 = zero (status bit 2).
- R4: With wr_en and alu_upd both high, a flag whose alu_mask bit is clear takes the written value.
- R5: Bits 4:3 of status ignore wr_en and wr_data entirely.
- R6: ev_wdt_to clears TO (bit 4) on the next edge. It takes precedence over any event that would set TO in the same cycle.
- R7: ev_clrwdt sets both TO and PD. ev_sleep sets TO and clears PD. When both arrive in the same cycle, PD is cleared.
- R8: bank_rp always equals status bits 6:5 and bank_irp always equals status bit 7. Without wr_en these bits hold their value.
- R9: With alu_upd high and wr_en low, flags with a clear mask bit, and all non-flag bits, keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-up |
| wr_en | input | 1 | Explicit register write strobe |
| wr_data | input | 8 | Data for the explicit write |
| alu_upd | input | 1 | ALU flag update strobe |
| alu_mask | input | 3 | Flags affected by the current instruction (zero, digit carry, carry) |
| alu_flags | input | 3 | ALU flag results (zero, digit carry, carry) |
| ev_wdt_to | input | 1 | Watchdog time-out event |
| ev_clrwdt | input | 1 | Clear-watchdog event |
| ev_sleep | input | 1 | Sleep entry event |
| status | output | 8 | Current register value |
| bank_rp | output | 2 | Data-memory bank select |
| bank_irp | output | 1 | Indirect-addressing bank select |

## Verification
Directed patterns come first, each aimed at one path. There is a pure write, a pure ALU update under each single-bit mask, and a write and ALU update together under masks of 000, 111 and mixed values; the mixed case tells per-bit arbitration apart from all-or-nothing suppression. A write of 0x00 and one of 0xFF show that the reset-cause bits never follow the data. Every pair of reset-cause events in the same cycle is applied to fix the precedence. A long random run then mixes all strobes, and a behavioural model checks every field on every cycle.

// File: rtl/status_reg_arb.sv
module status_reg_arb #(
  parameter logic [7:0] RESET_VAL = 8'h18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       alu_upd,
  input  logic [2:0] alu_mask,
  input  logic [2:0] alu_flags,
  input  logic       ev_wdt_to,
  input  logic       ev_clrwdt,
  input  logic       ev_sleep,
  output logic [7:0] status,
  output logic [1:0] bank_rp,
  output logic       bank_irp
);
  localparam int FLAG_W = 3;
  localparam int PD_B   = 3;
  localparam int TO_B   = 4;

  logic [FLAG_W-1:0] flag_q, flag_d, take_alu;
  logic [2:0]        bank_q;
  logic              to_q, pd_q;

  assign take_alu = alu_upd ? alu_mask : '0;

  always_comb begin
    flag_d = flag_q;
    if (wr_en) flag_d = wr_data[FLAG_W-1:0];
    flag_d = (flag_d & ~take_alu) | (alu_flags & take_alu);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RESET_VAL[FLAG_W-1:0];
      bank_q <= RESET_VAL[7:5];
      to_q   <= RESET_VAL[TO_B];
      pd_q   <= RESET_VAL[PD_B];
    end else begin
      flag_q <= flag_d;
      if (wr_en) bank_q <= wr_data[7:5];
      if (ev_wdt_to) to_q <= 1'b0;
      else if (ev_clrwdt || ev_sleep) to_q <= 1'b1;
      if (ev_sleep) pd_q <= 1'b0;
      else if (ev_clrwdt) pd_q <= 1'b1;
    end
  end

  assign status   = {bank_q, to_q, pd_q, flag_q};
  assign bank_rp  = status[6:5];
  assign bank_irp = status[7];

  a_r3_alu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    alu_upd |=> ((status[2:0] & $past(alu_mask)) == ($past(alu_flags) & $past(alu_mask))));
  a_r2_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !alu_upd) |=> (status[2:0] == $past(wr_data[2:0]) && status[7:5] == $past(wr_data[7:5])));
  a_r5_cause_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_wdt_to && !ev_clrwdt && !ev_sleep) |=> $stable(status[4:3]));
  a_r6_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt_to |=> !status[4]);
  a_r7_sleep_clears_pd: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sleep |=> !status[3]);
  a_r8_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({bank_irp, bank_rp}));
endmodule

// File: tb/tb_status_reg_arb.sv
module tb_status_reg_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, alu_upd = 0, ev_wdt_to = 0, ev_clrwdt = 0, ev_sleep = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] alu_mask = '0, alu_flags = '0;
  logic [7:0] status;
  logic [1:0] bank_rp;
  logic bank_irp;
  int checks = 0, fails = 0;
  int m_c, m_dc, m_z, m_to, m_pd, m_bank;

  always #4 clk = ~clk;

  status_reg_arb dut (.clk, .rst_n, .wr_en, .wr_data, .alu_upd, .alu_mask, .alu_flags,
    .ev_wdt_to, .ev_clrwdt, .ev_sleep, .status, .bank_rp, .bank_irp);

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R1/R2/R3/R4/R9 flags", status[2:0], m_z*4 + m_dc*2 + m_c);
    chk("R5/R6/R7 reset-cause", status[4:3], m_to*2 + m_pd);
    chk("R2/R8 bank bits", status[7:5], m_bank);
    chk("R8 bank outputs", {bank_irp, bank_rp}, m_bank);
  endtask

  task automatic model_reset();
    m_c = 0; m_dc = 0; m_z = 0; m_to = 1; m_pd = 1; m_bank = 0;
  endtask

  task automatic step(bit we, byte unsigned wd, bit au, int msk, int fl, bit wt, bit cw, bit sl);
    wr_en = we; wr_data = wd; alu_upd = au; alu_mask = msk[2:0]; alu_flags = fl[2:0];
    ev_wdt_to = wt; ev_clrwdt = cw; ev_sleep = sl;
    if (we) begin
      m_c = wd[0]; m_dc = wd[1]; m_z = wd[2]; m_bank = wd[7:5];
    end
    if (au && msk[0]) m_c = fl[0];
    if (au && msk[1]) m_dc = fl[1];
    if (au && msk[2]) m_z = fl[2];
    if (wt) m_to = 0; else if (cw || sl) m_to = 1;
    if (sl) m_pd = 0; else if (cw) m_pd = 1;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset value", status, 8'h18);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", status, 8'h18);
    compare();
    step(1, 8'hE7, 0, 0, 0, 0, 0, 0);
    step(1, 8'h00, 0, 0, 0, 0, 0, 0);
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1 << i, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1 << i, 7, 0, 0, 0);
    step(1, 8'h07, 1, 3'b000, 0, 0, 0, 0);
    step(1, 8'h00, 1, 3'b111, 7, 0, 0, 0);
    step(1, 8'h05, 1, 3'b010, 2, 0, 0, 0);
    step(1, 8'h02, 1, 3'b101, 5, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 8'hFF, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      step(r[0], byte'($urandom), r[1], int'(r[4:2]), int'(r[7:5]),
           r[12:8] == 0, r[17:13] == 0, r[22:18] == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule